// File: doc/BRIEF.md
# Iterative AES-Round Authenticated Encryption Sequencer

This block performs nonce-based authenticated encryption with associated data on 128-bit blocks. It reuses one AES-128 round datapath and one key-schedule step for every operation. Only two 128-bit values carry from block to block: the data state and the running key state. A packet opens with a `start` pulse that captures the nonce and the direction. Three full AES-128 calls then derive a session key and a starting state. After that the host streams associated-data blocks, message blocks and a final token. Every data block costs four keyed rounds. For a message block, sixteen bytes leaked from the state during those rounds form the keystream.

Blocks enter over a valid/ready port and results leave over a valid/ready port. `in_ready` never depends on `in_valid`. A block transfers on any rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output block stays unchanged. In encrypt mode, a ciphertext block waiting at the output stalls the input port. The master key must stay constant from `start` until `done`. A decrypt packet may carry at most `DEPTH` message blocks. Recovered plaintext is held inside the block until the tag matches, and is then released in order. A mismatch raises `auth_fail` and releases nothing.

Top module: `aead_seq`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `done` and `auth_fail` are all low until a packet is started.
- R2: On `start` in idle, the block sets session key S = AES(K, nonce) and starting state X0 = AES(S, AES(K, 0)). The key state is then left at the tenth round key of S, and the constant index restarts at 0.
- R3: An input block whose `in_kind` is 0 (associated data) is XORed into the state. The state then passes through four full AES rounds.
- R4: An input block whose `in_kind` is 1 (message) first runs four full AES rounds. After round j (1-based), keystream bytes 4(j-1)..4(j-1)+3 are state bytes 0,2,8,10 if j is odd and bytes 4,6,12,14 if j is even. Byte 0 is bits [127:120]. The output block is the input XOR the keystream.
- R5: After a message block, the plaintext is XORed into the state. In encrypt mode (`decrypt`=0) the plaintext is the input block. In decrypt mode it is the output block.
- R6: An input block whose `in_kind` has bit 1 set finalizes the packet. The tag is AES(K, state) and appears on `tag` when `done` pulses for one cycle.
- R7: In decrypt mode, `out_valid` stays low until the computed tag equals the block carried with the final token. The buffered plaintext blocks are then released in arrival order, and `done` follows.
- R8: On a decrypt tag mismatch, `auth_fail` goes high and stays high until the next start. `done` pulses, and no plaintext block is ever presented.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds. In encrypt mode `in_ready` is low while an output block is pending.
- R10: A `start` pulse while a packet is in progress has no effect on that packet's outputs or tag.
- R11: Every four-round block advances the key one schedule step per round. The round constant index carries across blocks and wraps modulo 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (used only in idle) |
| decrypt | input | 1 | Direction captured at start: 1 decrypt |
| master_key | input | 128 | Master key, stable for the packet |
| nonce | input | 128 | Nonce captured at start |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted when high with valid |
| in_kind | input | 2 | 0 associated data, 1 message, bit 1 set final |
| in_data | input | 128 | Block data; expected tag for a decrypt final |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 128 | Ciphertext or released plaintext |
| done | output | 1 | One-cycle end-of-packet strobe |
| tag | output | 128 | Computed tag of the last packet |
| auth_fail | output | 1 | Decrypt tag mismatch flag |

## Verification
The bench compares against its own bit-level model. It covers packets with no associated data, with no message, and with neither. Getting the derived starting state or the constant carry wrong would corrupt every tag. Swapping the odd and even leak patterns, or absorbing the wrong side of the XOR, changes the ciphertexts and breaks the decrypt round trip. A corrupted tag must release nothing: a design that streamed plaintext early or ignored the comparison would present blocks the scoreboard never expected. Random output back-pressure and a stray `start` in mid-packet expose a design that drops held data or restarts.

// File: rtl/aead_pkg.sv
package aead_pkg;
  localparam int NRC = 10;
  typedef logic [127:0] blk_t;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sub8(input logic [7:0] v);
    logic [7:0] sq, inv;
    sq  = v;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon_at(input logic [3:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int j = 0; j < NRC; j++)
      if (j < int'(idx)) r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
    return r;
  endfunction

  function automatic blk_t key_step(input blk_t k, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    {w0, w1, w2, w3} = k;
    t = {sub8(w3[23:16]) ^ rc, sub8(w3[15:8]), sub8(w3[7:0]), sub8(w3[31:24])};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  function automatic blk_t aes_round(input blk_t s, input blk_t k, input logic last);
    logic [7:0] b [16];
    logic [7:0] h [16];
    logic [7:0] a0, a1, a2, a3;
    blk_t t;
    for (int i = 0; i < 16; i++) b[i] = sub8(s[127-8*i -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) h[4*c+r] = b[4*((c+r)%4)+r];
    for (int c = 0; c < 4; c++) begin
      a0 = h[4*c]; a1 = h[4*c+1]; a2 = h[4*c+2]; a3 = h[4*c+3];
      if (last) t[127-32*c -: 32] = {a0, a1, a2, a3};
      else t[127-32*c -: 32] = {gmul(a0, 8'd2) ^ gmul(a1, 8'd3) ^ a2 ^ a3,
                                a0 ^ gmul(a1, 8'd2) ^ gmul(a2, 8'd3) ^ a3,
                                a0 ^ a1 ^ gmul(a2, 8'd2) ^ gmul(a3, 8'd3),
                                gmul(a0, 8'd3) ^ a1 ^ a2 ^ gmul(a3, 8'd2)};
    end
    return t ^ k;
  endfunction
endpackage

// File: rtl/aead_round.sv
module aead_round
  import aead_pkg::*;
(
  input  blk_t       st_i,
  input  blk_t       key_i,
  input  logic [7:0] rc_i,
  input  logic       last_i,
  output blk_t       st_o,
  output blk_t       key_o
);
  assign key_o = key_step(key_i, rc_i);
  assign st_o  = aes_round(st_i, key_o, last_i);
endmodule

// File: rtl/aead_pbuf.sv
module aead_pbuf #(
  parameter int W     = 128,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !clr |-> !empty);
endmodule

// File: rtl/aead_seq.sv
module aead_seq
  import aead_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         decrypt,
  input  logic [127:0] master_key,
  input  logic [127:0] nonce,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_kind,
  input  logic [127:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  output logic         done,
  output logic [127:0] tag,
  output logic         auth_fail
);
  typedef enum logic [2:0] {S_IDLE, S_INIT, S_READY, S_BLK, S_MIX, S_TAG, S_DRAIN} st_e;

  st_e fsm;
  blk_t st, key_q, hold, ks, tag_q, odata, st_nx, key_nx, mixed, b_rdata;
  logic [3:0] rnd, rc_q;
  logic [1:0] phase;
  logic is_msg, dec_q, ovalid, fail_q, done_q;
  logic full_mode, last_rnd, acc, tag_end;
  logic b_push, b_pop, b_clr, b_empty, b_full;
  logic [7:0]  rc_byte;
  logic [31:0] leak;

  assign full_mode = (fsm == S_INIT) || (fsm == S_TAG);
  assign last_rnd  = (rnd == 4'd10);
  assign rc_byte   = rcon_at(full_mode ? rnd - 4'd1 : rc_q);

  aead_round u_round (
    .st_i  (st),
    .key_i (key_q),
    .rc_i  (rc_byte),
    .last_i(full_mode && last_rnd),
    .st_o  (st_nx),
    .key_o (key_nx)
  );

  // byte m of the leak word: base positions 0,2,8,10, shifted by 4 in even rounds
  for (genvar m = 0; m < 4; m++) begin : g_leak
    localparam int BASE = (m < 2) ? 2 * m : 8 + 2 * (m - 2);
    assign leak[31-8*m -: 8] = rnd[0] ? st_nx[127-8*(BASE+4) -: 8] : st_nx[127-8*BASE -: 8];
  end

  assign mixed   = hold ^ ks;
  assign tag_end = (fsm == S_TAG) && last_rnd;
  assign in_ready = (fsm == S_READY) && !ovalid;
  assign acc      = in_valid && in_ready;

  assign b_push = (fsm == S_MIX) && dec_q;
  assign b_pop  = (fsm == S_DRAIN) && out_ready && !b_empty;
  assign b_clr  = ((fsm == S_IDLE) && start) || (tag_end && dec_q && (st_nx != hold));

  aead_pbuf #(.W(128), .DEPTH(DEPTH)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (b_clr),
    .push (b_push),
    .wdata(mixed),
    .pop  (b_pop),
    .rdata(b_rdata),
    .empty(b_empty),
    .full (b_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= S_IDLE;
      st <= '0; key_q <= '0; hold <= '0; ks <= '0; tag_q <= '0; odata <= '0;
      rnd <= '0; rc_q <= '0; phase <= '0;
      is_msg <= 1'b0; dec_q <= 1'b0; ovalid <= 1'b0; fail_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ovalid && out_ready) ovalid <= 1'b0;
      case (fsm)
        S_IDLE: if (start) begin
          dec_q <= decrypt;
          fail_q <= 1'b0;
          st <= nonce ^ master_key;
          key_q <= master_key;
          phase <= '0;
          rnd <= 4'd1;
          fsm <= S_INIT;
        end
        S_INIT: begin
          rnd <= rnd + 4'd1;
          st <= st_nx;
          key_q <= key_nx;
          if (last_rnd) begin
            rnd <= 4'd1;
            phase <= phase + 2'd1;
            case (phase)
              2'd0: begin hold <= st_nx; st <= master_key; key_q <= master_key; end
              2'd1: begin st <= st_nx ^ hold; key_q <= hold; end
              default: begin rc_q <= '0; fsm <= S_READY; end
            endcase
          end
        end
        S_READY: if (acc) begin
          rnd <= '0;
          if (in_kind[1]) begin
            hold <= in_data;
            st <= st ^ master_key;
            key_q <= master_key;
            rnd <= 4'd1;
            fsm <= S_TAG;
          end else begin
            is_msg <= in_kind[0];
            if (in_kind[0]) hold <= in_data;
            else st <= st ^ in_data;
            fsm <= S_BLK;
          end
        end
        S_BLK: begin
          st <= st_nx;
          key_q <= key_nx;
          rc_q <= (rc_q == 4'(NRC - 1)) ? '0 : rc_q + 4'd1;
          rnd <= rnd + 4'd1;
          ks[127-32*int'(rnd) -: 32] <= leak;
          if (rnd == 4'd3) fsm <= is_msg ? S_MIX : S_READY;
        end
        S_MIX: begin
          st <= st ^ (dec_q ? mixed : hold);
          if (!dec_q) begin
            odata <= mixed;
            ovalid <= 1'b1;
          end
          fsm <= S_READY;
        end
        S_TAG: begin
          rnd <= rnd + 4'd1;
          st <= st_nx;
          key_q <= key_nx;
          if (last_rnd) begin
            tag_q <= st_nx;
            if (!dec_q) begin
              done_q <= 1'b1;
              fsm <= S_IDLE;
            end else if (st_nx != hold) begin
              fail_q <= 1'b1;
              done_q <= 1'b1;
              fsm <= S_IDLE;
            end else fsm <= S_DRAIN;
          end
        end
        S_DRAIN: if (b_empty) begin
          done_q <= 1'b1;
          fsm <= S_IDLE;
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end

  assign out_valid = dec_q ? ((fsm == S_DRAIN) && !b_empty) : ovalid;
  assign out_data  = dec_q ? b_rdata : odata;
  assign done      = done_q;
  assign tag       = tag_q;
  assign auth_fail = fail_q;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_no_early_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_q && fsm != S_DRAIN |-> !out_valid);
  assert_fail_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    auth_fail |-> !out_valid);
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fsm != S_IDLE && start |=> $stable(dec_q));
  assert_rc_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q < 4'(NRC));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fsm == S_IDLE);
endmodule

// File: tb/aead_seq_test.sv
module aead_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, decrypt = 1'b0;
  logic [127:0] key_in = '0, nonce_in = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = '0;
  logic [127:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [127:0] out_data;
  logic done;
  logic [127:0] tag;
  logic auth_fail;

  int checks = 0, errors = 0;
  int early_cnt = 0, stall_err = 0, pend_err = 0, stall_seen = 0;
  logic pre_final = 1'b0;
  string mon_req = "R4";
  logic [127:0] exp_q[$];
  logic [127:0] ad_a[8], msg_a[8], mo_a[8], pt_a[8], ct_a[8];

  always #10 clk = ~clk;

  aead_seq #(.DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .master_key(key_in), .nonce(nonce_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .tag(tag), .auth_fail(auth_fail)
  );

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- behavioural model ----------------
  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0, bb = b;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) p ^= bb;
      bb = m_xt(bb);
    end
    return p;
  endfunction
  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = '0, o;
    logic [7:0] c = 8'h63;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return o;
  endfunction
  function automatic logic [7:0] m_rcon(input int i);
    logic [7:0] r = 8'h01;
    for (int j = 0; j < i; j++) r = m_xt(r);
    return r;
  endfunction
  function automatic logic [127:0] m_kstep(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] w [4];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    t = {m_sbox(w[3][23:16]) ^ rc, m_sbox(w[3][15:8]), m_sbox(w[3][7:0]), m_sbox(w[3][31:24])};
    w[0] ^= t;
    for (int i = 1; i < 4; i++) w[i] ^= w[i-1];
    return {w[0], w[1], w[2], w[3]};
  endfunction
  function automatic logic [127:0] m_round(input logic [127:0] s, input logic [127:0] k, input logic mix);
    logic [7:0] b [16];
    logic [7:0] o [16];
    logic [127:0] r;
    for (int i = 0; i < 16; i++) b[i] = m_sbox(s[127-8*i -: 8]);
    for (int i = 0; i < 16; i++) o[i] = b[(i + 4 * (i % 4)) % 16];
    for (int c = 0; c < 4; c++) begin
      for (int row = 0; row < 4; row++) begin
        if (mix)
          r[127-8*(4*c+row) -: 8] = m_mul(8'd2, o[4*c+row]) ^ m_mul(8'd3, o[4*c+(row+1)%4]) ^
                                    o[4*c+(row+2)%4] ^ o[4*c+(row+3)%4];
        else r[127-8*(4*c+row) -: 8] = o[4*c+row];
      end
    end
    return r ^ k;
  endfunction
  task automatic m_aes(input logic [127:0] k, input logic [127:0] p, output logic [127:0] c, output logic [127:0] kf);
    logic [127:0] s = p ^ k, kk = k;
    for (int r = 1; r <= 10; r++) begin
      kk = m_kstep(kk, m_rcon(r - 1));
      s = m_round(s, kk, r != 10);
    end
    c = s;
    kf = kk;
  endtask
  task automatic m_pkt(input logic dec, input logic [127:0] k, input logic [127:0] n,
                       input int nad, input int nm, output logic [127:0] tg);
    logic [127:0] sk, l, s, kk, dmy, ksb, o;
    int rc = 0, pos;
    m_aes(k, n, sk, dmy);
    m_aes(k, '0, l, dmy);
    m_aes(sk, l, s, kk);
    for (int i = 0; i < nad; i++) begin
      s ^= ad_a[i];
      for (int j = 0; j < 4; j++) begin
        kk = m_kstep(kk, m_rcon(rc)); rc = (rc + 1) % 10;
        s = m_round(s, kk, 1'b1);
      end
    end
    for (int i = 0; i < nm; i++) begin
      for (int j = 0; j < 4; j++) begin
        kk = m_kstep(kk, m_rcon(rc)); rc = (rc + 1) % 10;
        s = m_round(s, kk, 1'b1);
        for (int m = 0; m < 4; m++) begin
          pos = ((j % 2) ? 4 : 0) + ((m < 2) ? 2 * m : 8 + 2 * (m - 2));
          ksb[127-8*(4*j+m) -: 8] = s[127-8*pos -: 8];
        end
      end
      o = msg_a[i] ^ ksb;
      mo_a[i] = o;
      s ^= dec ? o : msg_a[i];
    end
    m_aes(k, s, tg, dmy);
  endtask

  // ---------------- driver ----------------
  task automatic send(input logic [1:0] kd, input logic [127:0] d);
    in_valid = 1'b1; in_kind = kd; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_pkt(input logic dec, input logic [127:0] k, input logic [127:0] n,
                         input int nad, input int nm, input logic [127:0] tag_in,
                         input logic poke, input string req, output logic [127:0] tg);
    logic exp_fail;
    m_pkt(dec, k, n, nad, nm, tg);
    exp_fail = dec && (tag_in != tg);
    if (!exp_fail) for (int i = 0; i < nm; i++) exp_q.push_back(mo_a[i]);
    mon_req = req; early_cnt = 0; pre_final = dec;
    @(negedge clk);
    start = 1'b1; decrypt = dec; key_in = k; nonce_in = n;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nad; i++) begin
      send(2'd0, ad_a[i]);
      if (poke && i == 0) begin  // R10: stray start mid-packet
        start = 1'b1; decrypt = ~dec; nonce_in = ~n;
        @(negedge clk);
        start = 1'b0; decrypt = dec; nonce_in = n;
      end
    end
    for (int i = 0; i < nm; i++) send(2'd1, msg_a[i]);
    send(2'd2, dec ? tag_in : '0);
    pre_final = 1'b0;
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, {req, " all outputs seen"}, 128'(exp_q.size()), '0);
    check(tag == tg, "R6 tag", tag, tg);
    check(auth_fail == exp_fail, "R8 auth_fail", 128'(auth_fail), 128'(exp_fail));
    if (dec) check(early_cnt == 0, "R7 no plaintext before tag", 128'(early_cnt), '0);
    exp_q.delete();
  endtask

  // ---------------- back-pressure and monitor ----------------
  initial begin
    logic [7:0] lf = 8'h5a;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[2];
    end
  end

  initial begin
    logic prev_stall = 1'b0;
    logic [127:0] prev_d = '0, e;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall && !(out_valid && out_data == prev_d)) stall_err++;
        if (out_valid && in_ready) pend_err++;
        prev_stall = out_valid && !out_ready;
        if (prev_stall) stall_seen++;
        prev_d = out_data;
        if (out_valid && out_ready) begin
          if (pre_final) early_cnt++;
          if (exp_q.size() == 0) check(1'b0, {mon_req, " unexpected output"}, out_data, '0);
          else begin
            e = exp_q.pop_front();
            check(out_data == e, {mon_req, " output block"}, out_data, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    logic [127:0] k1, n1, tg_a, tg, c, kf;
    k1 = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
    n1 = 128'h00000000_00000000_00000000_00000001;
    for (int i = 0; i < 8; i++) begin
      ad_a[i]  = {4{32'hA5A50000 + 32'(i)}} ^ 128'h0f0e0d0c_0b0a0908_07060504_03020100;
      pt_a[i]  = {4{32'h3C3C1111 * 32'(i + 1)}};
    end
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !done && !auth_fail, "R1 reset outputs",
          128'({in_ready, out_valid, done, auth_fail}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!in_ready && !out_valid && !done && !auth_fail, "R1 idle after reset",
          128'({in_ready, out_valid, done, auth_fail}), '0);

    m_aes(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff, c, kf);
    check(c == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 model cipher vector", c,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R3 R4 R10 R11: two AD, three message blocks, stray start
    for (int i = 0; i < 3; i++) msg_a[i] = pt_a[i];
    run_pkt(1'b0, k1, n1, 2, 3, '0, 1'b1, "R4", tg_a);
    for (int i = 0; i < 3; i++) ct_a[i] = mo_a[i];

    // R5 R7: decrypt round trip with correct tag
    for (int i = 0; i < 3; i++) msg_a[i] = ct_a[i];
    run_pkt(1'b1, k1, n1, 2, 3, tg_a, 1'b0, "R7", tg);
    for (int i = 0; i < 3; i++) check(mo_a[i] == pt_a[i], "R5 round trip", mo_a[i], pt_a[i]);

    // R8: corrupted tag releases nothing
    run_pkt(1'b1, k1, n1, 2, 3, tg_a ^ 128'h1, 1'b0, "R8", tg);

    // R4: no associated data
    for (int i = 0; i < 3; i++) msg_a[i] = pt_a[i + 3];
    run_pkt(1'b0, ~k1, n1 + 128'd7, 0, 2, '0, 1'b0, "R4", tg);

    // R3: no message blocks
    run_pkt(1'b0, k1, n1 + 128'd9, 2, 0, '0, 1'b0, "R3", tg);

    // R2: no blocks at all
    run_pkt(1'b0, k1 ^ 128'hff, n1, 0, 0, '0, 1'b0, "R2", tg);

    // R11: long packet, constant index wraps several times
    run_pkt(1'b0, k1, n1 + 128'd3, 4, 3, '0, 1'b0, "R11", tg);

    check(stall_err == 0, "R9 output held under back-pressure", 128'(stall_err), '0);
    check(pend_err == 0, "R9 input stalled while output pending", 128'(pend_err), '0);
    check(stall_seen > 0, "R9 back-pressure exercised", 128'(stall_seen), 128'(1));
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule